// File: doc/BRIEF.md
# BCH error location bit corrector

This block applies bit corrections to one 512-byte sector held in its own local RAM. A BCH error locator, outside this block, produces up to eight bit locations for the sector, a count of how many are valid, and a flag that marks the sector as beyond repair. The corrector also receives the stored parity field of the sector. After a start pulse it walks the valid locations one at a time. Locations that point into the parity field, or past the end of the data, are dropped. Each remaining location becomes a byte address and a one-hot bit mask, and the addressed byte goes through a read, an XOR and a write back.

The locator counts positions from the parity end of the codeword in reversed bit order. Each location therefore loses the parity width first, and the remaining offset is mirrored into a byte index. When the sector is an erased page, meaning every parity bit is one, the corrector leaves the data untouched. When the locator gives up, the corrector reports a failure. The sector RAM is loaded and read back through a simple host port. That port is ignored for writes while a correction is in progress.

Top module: `bch_bit_fixer`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `fail` and `erased` are low and `fixed_cnt` is zero.
- R2: A `start` pulse seen while idle is accepted. Either `busy` rises in the next cycle and stays high until the cycle in which `done` pulses, or `done` pulses in the next cycle directly. `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R3: A location L with L below the parity width (104 bits, so 0 to 103) flips no data bit and is not counted.
- R4: A location L of 104 or more is reduced to l = L - 104. Bit (l mod 8) of byte (4096 - l - 1) / 8 is then inverted. So L = 104 flips bit 0 of byte 511, and L = 4199 flips bit 7 of byte 0.
- R5: A location whose reduced offset l is 4096 or more lies beyond the data and is discarded without any write and without being counted.
- R6: Location slot i occupies bits [13*i +: 13] of `err_locs`. Only slots 0 to `err_cnt`-1 are used. A count of zero completes with no change to the sector.
- R7: When `uncorr` is set at start, the sector is not modified, `fail` is 1 and `fixed_cnt` is 0.
- R8: An `err_cnt` above 8 is treated as a failure, exactly as in R7.
- R9: When every bit of `par_bits` is 1, the sector is taken as erased. `erased` is set, `fail` stays 0, no data changes, and this check wins over `uncorr`. A single zero parity bit disables the check.
- R10: `fixed_cnt` equals the number of flips applied to the data region. A location given twice flips its bit twice and counts twice. `fail`, `erased` and `fixed_cnt` hold their values from `done` until the next accepted start.
- R11: When idle, a host write with `host_we` stores `host_wdata` at `host_addr`. `host_rdata` shows the byte at the `host_addr` of the previous cycle. Host writes while `busy` is high are ignored.
- R12: A `start` pulse while `busy` is high is ignored and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin correcting the sector with the present inputs |
| err_cnt | input | 4 | Number of valid location slots |
| uncorr | input | 1 | Locator reports the sector as uncorrectable |
| par_bits | input | 104 | Stored parity field of the sector |
| err_locs | input | 104 | Eight packed 13-bit error locations |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered RAM read data |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Correction refused |
| erased | output | 1 | Sector treated as erased, nothing corrected |
| fixed_cnt | output | 4 | Data bits flipped in the last run |

## Verification
The sector RAM has a single port. The host write path and the engine's write-back therefore compete for the same cycle. The bench provokes this by pulsing a host write, together with a second start, in the middle of a correction run. A later readback of the whole sector must show only the expected corrections, and the scoreboard must see exactly one completion. A second collision happens inside the engine itself. Repeated locations that hit the same byte, or even the same bit, are judged by the final byte value and the flip count.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  // Sequencer states: one location per FETCH..NEXT pass
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_NEXT  = 3'd4,
    ST_DONE  = 3'd5
  } fix_state_t;

  // Outcome chosen at start time
  typedef enum logic [1:0] {
    GO_WALK   = 2'd0,
    GO_ERASED = 2'd1,
    GO_FAIL   = 2'd2,
    GO_EMPTY  = 2'd3
  } fix_entry_t;

endpackage

// File: rtl/bch_parity_chk.sv
// Detects an erased sector: every parity nibble reads all ones.
module bch_parity_chk #(
  parameter int PAR_NIBBLES = 26,
  localparam int PAR_BITS   = PAR_NIBBLES * 4
) (
  input  logic [PAR_BITS-1:0] par_bits,
  output logic                all_ones
);

  logic [PAR_NIBBLES-1:0] nib_ones;

  generate
    for (genvar n = 0; n < PAR_NIBBLES; n++) begin : g_nib
      assign nib_ones[n] = &par_bits[n*4 +: 4];
    end
  endgenerate

  assign all_ones = &nib_ones;

endmodule

// File: rtl/bch_loc_map.sv
// Maps one raw locator position to a data byte address and bit mask.
module bch_loc_map #(
  parameter int DATA_BITS = 4096,
  parameter int PAR_BITS  = 104,
  parameter int LOC_W     = 13,
  parameter int ADDR_W    = 9
) (
  input  logic [LOC_W-1:0]  loc,
  output logic              hit,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        bit_mask
);

  localparam logic [LOC_W-1:0] PAR_L  = LOC_W'(PAR_BITS);
  localparam logic [LOC_W-1:0] DATA_L = LOC_W'(DATA_BITS);

  logic [LOC_W-1:0] rel;
  logic [LOC_W-1:0] mirror;
  logic             in_parity;
  logic             in_data;

  always_comb begin
    in_parity = (loc < PAR_L);
    rel       = loc - PAR_L;
    in_data   = (rel < DATA_L);
    // reversed bit order: offset 0 sits at the last data bit
    mirror    = DATA_L - LOC_W'(1) - rel;
    hit       = !in_parity && in_data;
    byte_addr = ADDR_W'(mirror >> 3);
    bit_mask  = 8'(1) << rel[2:0];
  end

endmodule

// File: rtl/bch_sector_ram.sv
// Single-port sector store, read-first, registered output.
module bch_sector_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end

endmodule

// File: rtl/bch_fix_seq.sv
// Read-modify-write sequencer walking the latched locations.
module bch_fix_seq
  import bch_fix_pkg::*;
#(
  parameter int MAX_LOC = 8,
  parameter int LOC_W   = 13,
  parameter int ADDR_W  = 9,
  localparam int CNT_W  = $clog2(MAX_LOC + 1),
  localparam int IDX_W  = (MAX_LOC > 1) ? $clog2(MAX_LOC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic                     uncorr,
  input  logic                     par_erased,
  input  logic [MAX_LOC*LOC_W-1:0] err_locs,
  // location mapper
  output logic [LOC_W-1:0]         cur_loc,
  input  logic                     map_hit,
  input  logic [ADDR_W-1:0]        map_addr,
  input  logic [7:0]               map_mask,
  // sector RAM
  output logic [ADDR_W-1:0]        ram_addr,
  output logic                     ram_we,
  output logic [7:0]               ram_wdata,
  input  logic [7:0]               ram_rdata,
  // status
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic                     erased,
  output logic [CNT_W-1:0]         fixed_cnt
);

  fix_state_t        state_q;
  fix_entry_t        entry;
  logic [LOC_W-1:0]  loc_q [MAX_LOC];
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        mask_q;
  logic              busy_q, done_q, fail_q, erased_q;
  logic [CNT_W-1:0]  fix_q;
  logic              last_loc;

  // entry decision; erased check outranks the locator verdict
  always_comb begin
    if (par_erased) begin
      entry = GO_ERASED;
    end else if (uncorr || (err_cnt > CNT_W'(MAX_LOC))) begin
      entry = GO_FAIL;
    end else if (err_cnt == '0) begin
      entry = GO_EMPTY;
    end else begin
      entry = GO_WALK;
    end
  end

  assign cur_loc  = loc_q[idx_q];
  assign last_loc = ((CNT_W'(idx_q) + CNT_W'(1)) == cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      mask_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      erased_q <= 1'b0;
      fix_q    <= '0;
      for (int i = 0; i < MAX_LOC; i++) begin
        loc_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            for (int i = 0; i < MAX_LOC; i++) begin
              loc_q[i] <= err_locs[i*LOC_W +: LOC_W];
            end
            cnt_q    <= err_cnt;
            idx_q    <= '0;
            fix_q    <= '0;
            fail_q   <= (entry == GO_FAIL);
            erased_q <= (entry == GO_ERASED);
            if (entry == GO_WALK) begin
              busy_q  <= 1'b1;
              state_q <= ST_FETCH;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
        end
        ST_FETCH: begin
          addr_q  <= map_addr;
          mask_q  <= map_mask;
          state_q <= map_hit ? ST_READ : ST_NEXT;
        end
        ST_READ: begin
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          fix_q   <= fix_q + CNT_W'(1);
          state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (last_loc) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_FETCH;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // RAM is addressed from the latched address; the read issued in READ
  // returns in WRITE, where the flipped byte goes back.
  assign ram_addr  = addr_q;
  assign ram_we    = (state_q == ST_WRITE);
  assign ram_wdata = ram_rdata ^ mask_q;

  assign busy      = busy_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign erased    = erased_q;
  assign fixed_cnt = fix_q;

endmodule

// File: rtl/bch_bit_fixer.sv
// Top: sector RAM, host port arbitration, mapper and sequencer.
module bch_bit_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int PAR_NIBBLES  = 26,
  parameter int MAX_LOC      = 8,
  localparam int DATA_BITS   = SECTOR_BYTES * 8,
  localparam int PAR_BITS    = PAR_NIBBLES * 4,
  localparam int LOC_W       = $clog2(DATA_BITS + PAR_BITS),
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int CNT_W       = $clog2(MAX_LOC + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic                     uncorr,
  input  logic [PAR_BITS-1:0]      par_bits,
  input  logic [MAX_LOC*LOC_W-1:0] err_locs,
  input  logic                     host_we,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic                     erased,
  output logic [CNT_W-1:0]         fixed_cnt
);

  logic              par_erased;
  logic [LOC_W-1:0]  cur_loc;
  logic              map_hit;
  logic [ADDR_W-1:0] map_addr;
  logic [7:0]        map_mask;
  logic [ADDR_W-1:0] eng_addr;
  logic              eng_we;
  logic [7:0]        eng_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;

  bch_parity_chk #(
    .PAR_NIBBLES (PAR_NIBBLES)
  ) par_chk_i (
    .par_bits (par_bits),
    .all_ones (par_erased)
  );

  bch_loc_map #(
    .DATA_BITS (DATA_BITS),
    .PAR_BITS  (PAR_BITS),
    .LOC_W     (LOC_W),
    .ADDR_W    (ADDR_W)
  ) loc_map_i (
    .loc       (cur_loc),
    .hit       (map_hit),
    .byte_addr (map_addr),
    .bit_mask  (map_mask)
  );

  bch_fix_seq #(
    .MAX_LOC (MAX_LOC),
    .LOC_W   (LOC_W),
    .ADDR_W  (ADDR_W)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .err_cnt    (err_cnt),
    .uncorr     (uncorr),
    .par_erased (par_erased),
    .err_locs   (err_locs),
    .cur_loc    (cur_loc),
    .map_hit    (map_hit),
    .map_addr   (map_addr),
    .map_mask   (map_mask),
    .ram_addr   (eng_addr),
    .ram_we     (eng_we),
    .ram_wdata  (eng_wdata),
    .ram_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .erased     (erased),
    .fixed_cnt  (fixed_cnt)
  );

  // The engine owns the single RAM port for the whole busy window.
  always_comb begin
    if (busy) begin
      mem_addr  = eng_addr;
      mem_we    = eng_we;
      mem_wdata = eng_wdata;
    end else begin
      mem_addr  = host_addr;
      mem_we    = host_we;
      mem_wdata = host_wdata;
    end
  end

  bch_sector_ram #(
    .DEPTH  (SECTOR_BYTES),
    .DATA_W (8)
  ) ram_i (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign host_rdata = mem_rdata;

endmodule

// File: rtl/bch_bit_fixer_chk.sv
// Temporal checks on the corrector's handshake and status.
module bch_bit_fixer_chk #(
  parameter int MAX_LOC = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             erased,
  input logic [CNT_W-1:0] fixed_cnt
);

  // R2: busy and done never overlap
  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: busy only ends through done
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R2: an idle start is always answered in the next cycle
  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done) |=> (busy || done));

  // R7: a failed run reports no flips
  a_r7_fail_no_fix: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (fixed_cnt == '0));

  // R9: an erased run neither fails nor flips
  a_r9_erased_clean: assert property (@(posedge clk) disable iff (rst)
    (done && erased) |-> (!fail && fixed_cnt == '0));

  // R10: the flip count never exceeds the slot count
  a_r10_fix_bound: assert property (@(posedge clk) disable iff (rst)
    fixed_cnt <= CNT_W'(MAX_LOC));

  // R10: status is held while idle and no start arrives
  a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(fail) && $stable(erased) && $stable(fixed_cnt)));

endmodule

bind bch_bit_fixer bch_bit_fixer_chk #(
  .MAX_LOC (MAX_LOC),
  .CNT_W   (CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .erased    (erased),
  .fixed_cnt (fixed_cnt)
);

// File: tb/bch_bit_fixer_tb_top.sv
module bch_bit_fixer_tb_top;

  localparam int SB      = 512;
  localparam int NLOC    = 8;
  localparam int LW      = 13;
  localparam int PB      = 104;
  localparam int WD_CYC  = 150000;

  logic            clk = 1'b0;
  logic            rst;
  logic            start;
  logic [3:0]      err_cnt;
  logic            uncorr;
  logic [PB-1:0]   par_bits;
  logic [NLOC*LW-1:0] err_locs;
  logic            host_we;
  logic [8:0]      host_addr;
  logic [7:0]      host_wdata;
  logic [7:0]      host_rdata;
  logic            busy, done, fail, erased;
  logic [3:0]      fixed_cnt;

  always #4 clk = ~clk;   // 125 MHz

  bch_bit_fixer dut_i (
    .clk(clk), .rst(rst), .start(start), .err_cnt(err_cnt), .uncorr(uncorr),
    .par_bits(par_bits), .err_locs(err_locs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .fail(fail), .erased(erased), .fixed_cnt(fixed_cnt)
  );

  typedef struct packed {
    logic       fail;
    logic       erased;
    logic [3:0] fixed;
  } exp_t;

  exp_t        sb_q[$];
  string       sb_tag[$];
  logic [7:0]  ref_mem [SB];
  int          tb_locs [NLOC];
  int          n_chk = 0;
  int          n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12 unexpected done", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        check(fail == e.fail, {t, " fail flag"}, int'(fail), int'(e.fail));
        check(erased == e.erased, {t, " erased flag"}, int'(erased), int'(e.erased));
        check(fixed_cnt == e.fixed, {t, " fixed count"}, int'(fixed_cnt), int'(e.fixed));
        check(!busy, "R2 busy low at done", int'(busy), 0);
      end
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = 9'(a);
    host_wdata = d;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic verify_mem(input string req);
    int bad = 0;
    int first_a = -1;
    int first_v = 0;
    for (int a = 0; a <= SB; a++) begin
      @(negedge clk);
      if (a > 0 && host_rdata !== ref_mem[a-1]) begin
        if (bad == 0) begin
          first_a = a - 1;
          first_v = int'(host_rdata);
        end
        bad++;
      end
      if (a < SB) host_addr = 9'(a);
    end
    if (bad != 0)
      check(1'b0, {req, " sector content"}, first_v, int'(ref_mem[first_a]));
    else
      check(1'b1, req, 0, 0);
  endtask

  // Driver: computes the expected outcome, pushes it, runs one sector
  task automatic run_case(input string tag, input int cnt, input bit unc,
                          input logic [PB-1:0] par, input bit poke);
    exp_t e;
    bit   shortcut;
    e = '0;
    if (&par) begin
      e.erased = 1'b1;                          // R9 precedence
    end else if (unc || cnt > NLOC) begin
      e.fail = 1'b1;                            // R7, R8
    end else begin
      for (int i = 0; i < cnt; i++) begin       // R6 slots 0..cnt-1
        int l;
        if (tb_locs[i] >= PB) begin             // R3 parity region skipped
          l = tb_locs[i] - PB;
          if (l < SB * 8) begin                 // R5 beyond data skipped
            ref_mem[(SB * 8 - l - 1) / 8] ^= 8'(1 << (l % 8));  // R4
            e.fixed++;
          end
        end
      end
    end
    shortcut = e.erased || e.fail || (cnt == 0);
    sb_q.push_back(e);
    sb_tag.push_back(tag);

    @(negedge clk);
    for (int i = 0; i < NLOC; i++) err_locs[i*LW +: LW] = LW'(tb_locs[i]);
    err_cnt  = 4'(cnt);
    uncorr   = unc;
    par_bits = par;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    if (shortcut)
      check(done && !busy, "R2 direct completion", int'(done), 1);
    else
      check(busy && !done, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      // R11/R12: host write and a second start inside the busy window
      host_we    = 1'b1;
      host_addr  = 9'd7;
      host_wdata = ~ref_mem[7];
      err_cnt    = 4'd0;
      start      = 1'b1;
      @(negedge clk);
      host_we    = 1'b0;
      start      = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    verify_mem({tag, " data"});
  endtask

  // Watchdog
  initial begin
    repeat (WD_CYC) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  logic [PB-1:0] par_ok;
  logic [PB-1:0] par_one_zero;

  initial begin
    rst = 1'b1; start = 1'b0; err_cnt = '0; uncorr = 1'b0;
    par_bits = '0; err_locs = '0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    par_ok = {13{8'hA5}};
    par_one_zero = '1;
    par_one_zero[50] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!busy, "R1 busy", int'(busy), 0);
    check(!done, "R1 done", int'(done), 0);
    check(!fail, "R1 fail", int'(fail), 0);
    check(!erased, "R1 erased", int'(erased), 0);
    check(fixed_cnt == 0, "R1 fixed_cnt", int'(fixed_cnt), 0);

    // R11 host load of a known pattern
    for (int a = 0; a < SB; a++) begin
      ref_mem[a] = 8'((a * 7 + 3) ^ (a >> 3));
      host_write(a, ref_mem[a]);
    end
    verify_mem("R11 host load");

    // R3/R4 boundaries plus R11/R12 contention during the run
    tb_locs = '{104, 4199, 103, 1000, 0, 0, 0, 0};
    run_case("R4 boundaries", 4, 1'b0, par_ok, 1'b1);

    // R7 uncorrectable: data untouched
    tb_locs = '{500, 600, 700, 0, 0, 0, 0, 0};
    run_case("R7 uncorrectable", 3, 1'b1, par_ok, 1'b0);

    // R9 erased wins over uncorrectable
    run_case("R9 erased", 3, 1'b1, '1, 1'b0);

    // R9 one parity bit clear: not erased, correction runs
    tb_locs = '{300, 0, 0, 0, 0, 0, 0, 0};
    run_case("R9 not erased", 1, 1'b0, par_one_zero, 1'b0);

    // R8 count above eight
    run_case("R8 count overflow", 9, 1'b0, par_ok, 1'b0);

    // R5/R6/R10 repeated bit, shared byte, out-of-range, unused slots
    tb_locs = '{200, 200, 207, 5000, 300, 400, 500, 600};
    run_case("R10 duplicates", 4, 1'b0, par_ok, 1'b0);

    // R6 empty run
    run_case("R6 zero count", 0, 1'b0, par_ok, 1'b0);

    // R10 full eight slots, status held afterwards
    tb_locs = '{110, 2000, 3333, 4100, 4150, 900, 1500, 4195};
    run_case("R10 eight slots", 8, 1'b0, par_ok, 1'b0);
    repeat (3) @(negedge clk);
    check(fixed_cnt == 4'd8, "R10 status held", int'(fixed_cnt), 8);

    // R11 idle write then read back
    ref_mem[42] = 8'h5C;
    host_write(42, 8'h5C);
    verify_mem("R11 idle write");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R2 all completions seen", sb_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule